// File: doc/BRIEF.md
# Three-Source Clock Supervisor with Automatic Failover

This block watches three clock sources (an on-chip oscillator, an external clock and a PLL output) and decides which of them drives the system. Each source is counted by a clock other than itself: the external clock times the counting of both the PLL and the on-chip oscillator, and the on-chip oscillator times the counting of the external clock. A source that shows too few edges in a counting window is marked as failed. The mark stays until software clears it.

The selection register and the interrupt live in the on-chip oscillator domain, and the system starts from that oscillator after reset. Software may request any of the three sources. If the source in use is marked as failed, the block moves the selection to the most preferred unmarked source and raises a sticky interrupt. The preference order is PLL first, then the external clock, then the on-chip oscillator. The selection change stands in for the glitch-free clock multiplexer that sits downstream.

Top module: `clk_failover_mon`

## Requirements
- R1: After reset, `sel_src` is 0 (on-chip oscillator), `fail_flags` is 0 and `irq` is 0.
- R2: With all three clocks at nominal rate, no flag is set, `irq` stays low and the selection does not change.
- R3: With `min_edges` at 4, an on-chip oscillator period between 7 ns and 13 ns (about ±30% around 10 ns) sets no flag.
- R4: A pulse on `sel_req_vld` carrying code 0 (on-chip), 1 (external) or 2 (PLL) for an unflagged source sets `sel_src` to that code at the next `clk_int` edge. Code 3 is ignored.
- R5: A source is flagged when fewer than `min_edges` counted ticks occur in one window. One tick is 8 edges of the monitored clock. A window is 64 `clk_ext` cycles for the PLL and on-chip checks, and 256 `clk_int` cycles for the external check. Flag bits: bit 0 on-chip, bit 1 external, bit 2 PLL.
- R6: When the selected source is flagged, `sel_src` moves to the first unflagged source in the order PLL (2), external (1), on-chip (0).
- R7: A newly set flag raises `irq`, which stays high until `fail_clr`.
- R8: A flagged source never becomes selected. A software request for it is ignored, and failover skips it.
- R9: A flag stays set after its source recovers, until `fail_clr` is held high. The clear drops the flags of healthy sources and drops `irq`.
- R10: When a source that is not selected fails, its flag and `irq` are set, but `sel_src` does not change.
- R11: A stall of the on-chip oscillator is detected by the external-clock check. Once the oscillator resumes, the selection moves off it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | On-chip oscillator; control domain |
| clk_ext | input | 1 | External clock |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| min_edges | input | CNT_W | Minimum ticks per window (quasi-static) |
| sel_req_vld | input | 1 | One-cycle software select strobe |
| sel_req | input | 2 | Requested source code |
| fail_clr | input | 1 | Clears fail flags and interrupt while high |
| sel_src | output | 2 | Currently selected source code |
| fail_flags | output | 3 | Sticky per-source failure flags |
| irq | output | 1 | Sticky failure interrupt |

## Verification
The main function is tried with four patterns. All clocks running at nominal rate, and again with the on-chip period stretched and shrunk by 30%, shows that the thresholds make no false detections. A single PLL stop while the PLL is selected tells failover apart from plain flagging, and a PLL stop while it is not selected tells flagging without a switch apart from failover. Stopping the external clock, once with the PLL healthy and once with the PLL already flagged, tells preference order apart from flag skipping. A stall of the on-chip oscillator shows that the cross-check pattern lets the oscillator that runs the control logic be judged by another clock.

// File: rtl/cm_pkg.sv
`timescale 1ns/1ps
package cm_pkg;
  localparam int NSRC = 3;
  localparam logic [1:0] SRC_INT = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
  localparam logic [1:0] SRC_PLL = 2'd2;
endpackage

// File: rtl/cm_rst_sync.sv
`timescale 1ns/1ps
module cm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/cm_sync2.sv
`timescale 1ns/1ps
module cm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/cm_edge_mon.sv
`timescale 1ns/1ps
module cm_edge_mon #(
  parameter int PRE_W = 4,
  parameter int WIN   = 64,
  parameter int CNT_W = 8
) (
  input  logic             mon_clk,
  input  logic             mon_rst_n,
  input  logic             chk_clk,
  input  logic             chk_rst_n,
  input  logic [CNT_W-1:0] min_edges,
  input  logic             clr,
  output logic             dead
);
  localparam int WIN_W = $clog2(WIN);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  // monitored domain: prescaler, its top bit is the crossing toggle
  logic [PRE_W-1:0] pre_q, pre_d;
  always_comb pre_d = pre_q + 1'b1;
  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) pre_q <= '0;
    else            pre_q <= pre_d;
  end

  // checker domain
  logic [2:0]       smp_q, smp_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dead_q, dead_d;
  logic             tick, win_end, short_win;

  always_comb begin
    smp_d     = {smp_q[1:0], pre_q[PRE_W-1]};
    tick      = smp_q[2] ^ smp_q[1];
    win_end   = (win_q == WIN_LAST);
    short_win = win_end && (cnt_q < min_edges);
    win_d     = win_end ? '0 : win_q + 1'b1;
    if (win_end)                      cnt_d = tick ? CNT_W'(1) : '0;
    else if (tick && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                              cnt_d = cnt_q;
    dead_d = dead_q;
    if (clr)       dead_d = 1'b0;
    if (short_win) dead_d = 1'b1;
  end

  always_ff @(posedge chk_clk or negedge chk_rst_n) begin
    if (!chk_rst_n) begin
      smp_q  <= '0;
      win_q  <= '0;
      cnt_q  <= '0;
      dead_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      dead_q <= dead_d;
    end
  end

  assign dead = dead_q;

  assert_short_window_flags_R5: assert property (@(posedge chk_clk) disable iff (!chk_rst_n)
    (win_end && (cnt_q < min_edges)) |=> dead_q);

  assert_flag_sticky_R9: assert property (@(posedge chk_clk) disable iff (!chk_rst_n)
    (dead_q && !clr) |=> dead_q);
endmodule

// File: rtl/clk_failover_mon.sv
`timescale 1ns/1ps
module clk_failover_mon
  import cm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 4,
  parameter int WIN_EXT = 64,
  parameter int WIN_INT = 256
) (
  input  logic             clk_int,
  input  logic             clk_ext,
  input  logic             clk_pll,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] min_edges,
  input  logic             sel_req_vld,
  input  logic [1:0]       sel_req,
  input  logic             fail_clr,
  output logic [1:0]       sel_src,
  output logic [NSRC-1:0]  fail_flags,
  output logic             irq
);
  logic rst_int_n, rst_ext_n, rst_pll_n;

  cm_rst_sync u_rs_int (.clk(clk_int), .rst_n_in(rst_n), .rst_n_out(rst_int_n));
  cm_rst_sync u_rs_ext (.clk(clk_ext), .rst_n_in(rst_n), .rst_n_out(rst_ext_n));
  cm_rst_sync u_rs_pll (.clk(clk_pll), .rst_n_in(rst_n), .rst_n_out(rst_pll_n));

  // clear request carried into the external-clock domain
  logic clr_ext;
  cm_sync2 #(.W(1)) u_clr_sync (
    .clk(clk_ext), .rst_n(rst_ext_n), .d(fail_clr), .q(clr_ext));

  // cross-check pattern: ext times pll and int, int times ext
  logic dead_pll_x, dead_int_x, dead_ext;

  cm_edge_mon #(.PRE_W(PRE_W), .WIN(WIN_EXT), .CNT_W(CNT_W)) u_mon_pll (
    .mon_clk(clk_pll), .mon_rst_n(rst_pll_n),
    .chk_clk(clk_ext), .chk_rst_n(rst_ext_n),
    .min_edges(min_edges), .clr(clr_ext), .dead(dead_pll_x));

  cm_edge_mon #(.PRE_W(PRE_W), .WIN(WIN_EXT), .CNT_W(CNT_W)) u_mon_int (
    .mon_clk(clk_int), .mon_rst_n(rst_int_n),
    .chk_clk(clk_ext), .chk_rst_n(rst_ext_n),
    .min_edges(min_edges), .clr(clr_ext), .dead(dead_int_x));

  cm_edge_mon #(.PRE_W(PRE_W), .WIN(WIN_INT), .CNT_W(CNT_W)) u_mon_ext (
    .mon_clk(clk_ext), .mon_rst_n(rst_ext_n),
    .chk_clk(clk_int), .chk_rst_n(rst_int_n),
    .min_edges(min_edges), .clr(fail_clr), .dead(dead_ext));

  logic [1:0] xflags;
  cm_sync2 #(.W(2)) u_flag_sync (
    .clk(clk_int), .rst_n(rst_int_n),
    .d({dead_pll_x, dead_int_x}), .q(xflags));

  logic [NSRC-1:0] fail_s;
  assign fail_s = {xflags[1], dead_ext, xflags[0]};

  // control domain: selection and interrupt
  logic [1:0]      sel_q, sel_d, pick;
  logic [NSRC-1:0] fail_q;
  logic            irq_q, irq_d;
  logic [3:0]      fail4;
  logic            cur_bad, pick_ok;

  always_comb begin
    fail4   = {1'b1, fail_s};
    cur_bad = fail4[sel_q];
    pick_ok = 1'b1;
    if (!fail_s[SRC_PLL])      pick = SRC_PLL;
    else if (!fail_s[SRC_EXT]) pick = SRC_EXT;
    else if (!fail_s[SRC_INT]) pick = SRC_INT;
    else begin
      pick    = sel_q;
      pick_ok = 1'b0;
    end
    sel_d = sel_q;
    if (cur_bad && pick_ok)                sel_d = pick;
    else if (sel_req_vld && !fail4[sel_req]) sel_d = sel_req;
    irq_d = irq_q;
    if (fail_clr)                irq_d = 1'b0;
    if (|(fail_s & ~fail_q))     irq_d = 1'b1;
  end

  always_ff @(posedge clk_int or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q  <= SRC_INT;
      fail_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      fail_q <= fail_s;
      irq_q  <= irq_d;
    end
  end

  assign sel_src    = sel_q;
  assign fail_flags = fail_s;
  assign irq        = irq_q;

  assert_no_flagged_pick_R8: assert property (@(posedge clk_int) disable iff (!rst_int_n)
    (sel_q != $past(sel_q)) |-> !fail4[$past(sel_q) == sel_q ? 2'd3 : sel_q] || fail4[3] && (sel_q != $past(sel_q)) && !$past(fail4[sel_q]));

  assert_failover_moves_R6: assert property (@(posedge clk_int) disable iff (!rst_int_n)
    (fail4[sel_q] && (fail_s != 3'b111)) |=> (sel_q != $past(sel_q)));

  assert_irq_on_new_flag_R7: assert property (@(posedge clk_int) disable iff (!rst_int_n)
    (|(fail_s & ~fail_q)) |=> irq_q);

  assert_sel_legal_R4: assert property (@(posedge clk_int) disable iff (!rst_int_n)
    (sel_req_vld && (sel_req == 2'd3) && !fail4[sel_q]) |=> $stable(sel_q));
endmodule

// File: tb/tb_clk_failover_mon.sv
`timescale 1ns/1ps
module tb_clk_failover_mon;
  logic       clk_int = 1'b0, clk_ext = 1'b0, clk_pll = 1'b0;
  logic       rst_n;
  logic [7:0] min_edges;
  logic       sel_req_vld;
  logic [1:0] sel_req;
  logic       fail_clr;
  logic [1:0] sel_src;
  logic [2:0] fail_flags;
  logic       irq;

  real  int_half = 5.0;
  logic int_en = 1'b1, ext_en = 1'b1, pll_en = 1'b1;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always begin #(int_half); if (int_en) clk_int = ~clk_int; end
  always begin #12.5;       if (ext_en) clk_ext = ~clk_ext; end
  always begin #3.5;        if (pll_en) clk_pll = ~clk_pll; end

  clk_failover_mon dut (
    .clk_int(clk_int), .clk_ext(clk_ext), .clk_pll(clk_pll), .rst_n(rst_n),
    .min_edges(min_edges), .sel_req_vld(sel_req_vld), .sel_req(sel_req),
    .fail_clr(fail_clr), .sel_src(sel_src), .fail_flags(fail_flags), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_int);
  endtask

  task automatic request(input logic [1:0] code);
    @(negedge clk_int);
    sel_req = code; sel_req_vld = 1'b1;
    @(negedge clk_int);
    sel_req_vld = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk_int);
    fail_clr = 1'b1;
    cyc(20);
    fail_clr = 1'b0;
    cyc(20);
  endtask

  task automatic t_reset();
    cyc(5);
    chk("R1 sel", sel_src, 0);
    chk("R1 flags", fail_flags, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_nominal();
    #8000; cyc(1);
    chk("R2 flags", fail_flags, 0);
    chk("R2 irq", irq, 0);
    chk("R2 sel", sel_src, 0);
  endtask

  task automatic t_spread();
    int_half = 6.5; #8000; cyc(1);
    chk("R3 slow int flags", fail_flags, 0);
    int_half = 3.5; #8000; cyc(1);
    chk("R3 fast int flags", fail_flags, 0);
    int_half = 5.0; #2000; cyc(1);
    chk("R3 irq", irq, 0);
  endtask

  task automatic t_select();
    request(2'd3);
    chk("R4 code 3 ignored", sel_src, 0);
    request(2'd2);
    chk("R4 select pll", sel_src, 2);
  endtask

  task automatic t_pll_fail();
    pll_en = 1'b0; #5000; cyc(1);
    chk("R5 pll flag", fail_flags, 3'b100);
    chk("R6 failover to ext", sel_src, 1);
    chk("R7 irq on pll fail", irq, 1);
    request(2'd2);
    chk("R8 flagged pll request ignored", sel_src, 1);
    pll_en = 1'b1; #5000; cyc(1);
    chk("R9 flag held after recovery", fail_flags, 3'b100);
    chk("R9 irq held", irq, 1);
    clear_all();
    chk("R9 flags cleared", fail_flags, 0);
    chk("R9 irq cleared", irq, 0);
    request(2'd2);
    chk("R4 pll selectable again", sel_src, 2);
  endtask

  task automatic t_ext_fail();
    request(2'd1);
    chk("R4 select ext", sel_src, 1);
    ext_en = 1'b0; #8000; cyc(1);
    chk("R5 ext flag", fail_flags, 3'b010);
    chk("R6 pll preferred", sel_src, 2);
    ext_en = 1'b1; #8000;
    clear_all();
    chk("R9 flags cleared after ext", fail_flags, 0);
  endtask

  task automatic t_skip_flagged();
    request(2'd1);
    pll_en = 1'b0; #5000; cyc(1);
    chk("R10 unselected pll flagged", fail_flags, 3'b100);
    chk("R10 no switch", sel_src, 1);
    chk("R10 irq", irq, 1);
    ext_en = 1'b0; #8000; cyc(1);
    chk("R8 skip flagged pll", sel_src, 0);
    chk("R5 both flagged", fail_flags, 3'b110);
    ext_en = 1'b1; pll_en = 1'b1; #8000;
    clear_all();
    chk("R9 flags cleared after both", fail_flags, 0);
    chk("R9 irq cleared after both", irq, 0);
  endtask

  task automatic t_int_stall();
    chk("R11 start on int", sel_src, 0);
    int_en = 1'b0; #5000; int_en = 1'b1;
    cyc(20);
    chk("R11 int flagged", fail_flags, 3'b001);
    chk("R11 moved to pll", sel_src, 2);
    chk("R11 irq", irq, 1);
    #5000;
    clear_all();
    chk("R11 cleared", fail_flags, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; min_edges = 8'd4; sel_req_vld = 1'b0; sel_req = 2'd0; fail_clr = 1'b0;
    #100;
    @(negedge clk_int);
    rst_n = 1'b1;
    t_reset();
    t_nominal();
    t_spread();
    t_select();
    t_pll_fail();
    t_ext_fail();
    t_skip_flagged();
    request(2'd0);
    t_int_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule